// File: doc/BRIEF.md
# Paced Up/Down Counter with Decimal Seven-Segment Display

This block holds a binary count and moves it by one on each slow enable tick. A prescaler divides the fast system clock into those ticks. A direction input chooses whether each tick adds one or subtracts one. A load input copies a value from a parallel input straight into the count. A synchronous reset clears the count.

The count is available as a raw binary bus. It also drives four seven-segment digit buses that show the value in decimal. Each digit bus is active-low, so a segment is lit when its bit is 0. A combinational shift-and-add-3 network turns the count into thousands, hundreds, tens and units.

The prescale length is a parameter. It defaults to 20,000,000 cycles, which gives about 0.4 s between steps from a 50 MHz clock. A bench can set a small value instead.

Top module: `updn_decimal_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 and the prescaler restarts, even if `loadEn` is high at the same edge.
- R2: When neither reset nor load is active, the count changes only on a tick. With `rst` and `loadEn` low, a tick comes at every PRESCALE-th rising edge after reset is released: edge PRESCALE, edge 2*PRESCALE, and so on. A load does not shift this tick timing.
- R3: On a tick, the count rises by one when `dirUp` is 1 and falls by one when `dirUp` is 0.
- R4: Counting up from 1023 gives 0, and counting down from 0 gives 1023.
- R5: When `loadEn` is high at an edge and `rst` is low, the count takes `loadVal` at that edge. This happens whether or not a tick is due, and a tick at the same edge is lost.
- R6: `seg0` shows the units digit of `count` in decimal, `seg1` the tens, `seg2` the hundreds and `seg3` the thousands. Leading zeros are shown as the digit 0, not as blanks.
- R7: Each digit bus is active-low. Bit 6 is segment g and bit 0 is segment a. The codes for digits 0 to 9 are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000. Any non-decimal digit code shows the blank pattern 1111111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dirUp | input | 1 | 1 counts up on a tick, 0 counts down |
| loadEn | input | 1 | Copies loadVal into the count |
| loadVal | input | 10 | Value used by a load |
| seg0 | output | 7 | Units digit, active-low, bits g down to a |
| seg1 | output | 7 | Tens digit, active-low |
| seg2 | output | 7 | Hundreds digit, active-low |
| seg3 | output | 7 | Thousands digit, active-low |
| count | output | 10 | Raw binary count |

## Verification
The bench targets wrap-around in both directions, 1023 to 0 and 0 to 1023. A design that saturated, or skipped a value, would show a wrong count and a wrong digit on the very next tick. It holds a load across a cycle where a tick is due and asserts reset together with load. A wrong priority would either step off the loaded value or keep the loaded value instead of clearing. It loads values whose decimal digits are mixed and contain zeros, such as 1009, 987 and 40. These expose a wrong add-3 threshold in the conversion, swapped digit positions, or blanked leading zeros. It also checks each step's timing cycle by cycle against the prescale period. A prescaler that is off by one, or that restarts on a load, drifts out of step with the expected ticks.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Strobes from control to datapath; at most one of clr/load/step is set.
  typedef struct packed {
    logic clr;
    logic load;
    logic step;
    logic up;
  } ctlStrobes_t;

  localparam int SEG_W = 7;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
#(
  parameter int PRESCALE = 20_000_000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dirUp,
  input  logic        loadEn,
  output ctlStrobes_t strb
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] preCnt;
  logic          tick;

  assign tick = (preCnt == LAST) && !rst;

  always_ff @(posedge clk) begin
    if (rst || tick) preCnt <= '0;
    else             preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    strb.clr  = rst;
    strb.load = !rst && loadEn;
    strb.step = !rst && !loadEn && tick;
    strb.up   = dirUp;
  end

  // R5: priority leaves at most one action strobe active
  assert_one_action_R5: assert property (@(posedge clk)
    $onehot0({strb.clr, strb.load, strb.step}));

  // R2: prescaler never passes its terminal value
  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (rst)
    preCnt <= LAST);

  generate
    if (PRESCALE > 1) begin : g_pulse
      // R2: tick lasts exactly one cycle
      assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DIGITS = 4
) (
  input  logic                         clk,
  input  ctlStrobes_t                  strb,
  input  logic [CNT_W-1:0]             loadVal,
  output logic [CNT_W-1:0]             count,
  output logic [DIGITS-1:0][SEG_W-1:0] segs
);
  localparam int BCD_W = 4 * DIGITS;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [BCD_W-1:0] bcd;

  always_ff @(posedge clk) begin
    if (strb.clr)       count <= '0;
    else if (strb.load) count <= loadVal;
    else if (strb.step) count <= strb.up ? count + 1'b1 : count - 1'b1;
  end

  // Shift-and-add-3 conversion, one pass per input bit.
  function automatic logic [BCD_W-1:0] toBcd(input logic [CNT_W-1:0] bin);
    logic [BCD_W-1:0] acc;
    acc = '0;
    for (int b = CNT_W - 1; b >= 0; b--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], bin[b]};
    end
    return acc;
  endfunction

  function automatic logic [SEG_W-1:0] segCode(input logic [3:0] dig);
    case (dig)
      4'd0:    segCode = 7'b1000000;
      4'd1:    segCode = 7'b1111001;
      4'd2:    segCode = 7'b0100100;
      4'd3:    segCode = 7'b0110000;
      4'd4:    segCode = 7'b0011001;
      4'd5:    segCode = 7'b0010010;
      4'd6:    segCode = 7'b0000010;
      4'd7:    segCode = 7'b1111000;
      4'd8:    segCode = 7'b0000000;
      4'd9:    segCode = 7'b0010000;
      default: segCode = 7'b1111111;
    endcase
  endfunction

  assign bcd = toBcd(count);

  generate
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assign segs[g] = segCode(bcd[4*g +: 4]);
      // R6: every converted digit is a decimal digit
      assert_digit_range_R6: assert property (@(posedge clk) disable iff (strb.clr)
        bcd[4*g +: 4] <= 4'd9);
    end
  endgenerate

  // R1: clear takes effect on the next edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    strb.clr |=> (count == '0));

  // R5: load captures the supplied value
  assert_load_value_R5: assert property (@(posedge clk) disable iff (strb.clr)
    strb.load |=> (count == $past(loadVal)));

  // R2: no action means no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (strb.clr)
    (!strb.load && !strb.step) |=> $stable(count));

  // R4: wrap in both directions
  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (strb.clr)
    (strb.step && strb.up && count == MAXV) |=> (count == '0));
  assert_wrap_down_R4: assert property (@(posedge clk) disable iff (strb.clr)
    (strb.step && !strb.up && count == '0) |=> (count == MAXV));

  // R3: ordinary down step
  assert_down_step_R3: assert property (@(posedge clk) disable iff (strb.clr)
    (strb.step && !strb.up && count != '0) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/updn_decimal_counter.sv
module updn_decimal_counter
  import updn_pkg::*;
#(
  parameter int PRESCALE = 20_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dirUp,
  input  logic       loadEn,
  input  logic [9:0] loadVal,
  output logic [6:0] seg0,
  output logic [6:0] seg1,
  output logic [6:0] seg2,
  output logic [6:0] seg3,
  output logic [9:0] count
);
  localparam int CNT_W  = 10;
  localparam int DIGITS = 4;

  ctlStrobes_t                  strb;
  logic [DIGITS-1:0][SEG_W-1:0] segs;

  updn_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rst(rst), .dirUp(dirUp), .loadEn(loadEn), .strb(strb)
  );

  updn_datapath #(.CNT_W(CNT_W), .DIGITS(DIGITS)) u_dp (
    .clk(clk), .strb(strb), .loadVal(loadVal), .count(count), .segs(segs)
  );

  assign seg0 = segs[0];
  assign seg1 = segs[1];
  assign seg2 = segs[2];
  assign seg3 = segs[3];
endmodule

// File: tb/tb_updn_decimal_counter.sv
`timescale 1ns/1ps
module tb_updn_decimal_counter;
  localparam int P = 4;

  logic       clk = 0;
  logic       rst = 1;
  logic       dirUp = 1;
  logic       loadEn = 0;
  logic [9:0] loadVal = '0;
  logic [6:0] seg0, seg1, seg2, seg3;
  logic [9:0] count;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int    cnt;
    string tag;
  } expItem_t;
  expItem_t q[$];

  int mCnt = 0;
  int mPh = 0;

  always #2.5 clk = ~clk;

  updn_decimal_counter #(.PRESCALE(P)) dut (
    .clk(clk), .rst(rst), .dirUp(dirUp), .loadEn(loadEn), .loadVal(loadVal),
    .seg0(seg0), .seg1(seg1), .seg2(seg2), .seg3(seg3), .count(count)
  );

  function automatic logic [6:0] segOf(int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      9: return 7'b0010000;
      default: return 7'b1111111;
    endcase
  endfunction

  // Driver: runs n cycles with the current inputs, pushing expectations.
  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst) begin
        mCnt = 0;
        mPh  = 0;
      end else begin
        bit tk;
        tk = (mPh == P - 1);
        mPh = tk ? 0 : mPh + 1;
        if (loadEn)  mCnt = int'(loadVal);
        else if (tk) mCnt = dirUp ? (mCnt + 1) % 1024 : (mCnt + 1023) % 1024;
      end
      q.push_back('{cnt: mCnt, tag: tag});
      @(negedge clk);
    end
  endtask

  // Monitor: compares outputs against the queue away from the edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      expItem_t e;
      logic [6:0] eS0, eS1, eS2, eS3;
      e = q.pop_front();
      eS0 = segOf(e.cnt % 10);
      eS1 = segOf((e.cnt / 10) % 10);
      eS2 = segOf((e.cnt / 100) % 10);
      eS3 = segOf(e.cnt / 1000);
      checks++;
      if (int'(count) != e.cnt) begin
        errors++;
        $display("FAIL %s count: actual %0d expected %0d", e.tag, count, e.cnt);
      end
      checks++;
      if ({seg3, seg2, seg1, seg0} != {eS3, eS2, eS1, eS0}) begin
        errors++;
        $display("FAIL R6/R7 (%s) segs at %0d: actual %b_%b_%b_%b expected %b_%b_%b_%b",
                 e.tag, e.cnt, seg3, seg2, seg1, seg0, eS3, eS2, eS1, eS0);
      end
    end
  end

  initial begin
    // R1: reset while load is requested
    loadEn = 1; loadVal = 10'd500;
    run(3, "R1 reset over load");
    loadEn = 0; rst = 0;
    // R2, R3: tick pacing, counting up
    dirUp = 1;
    run(5 * P, "R2 R3 up pacing");
    // R5: single-cycle load mid period, then R4 wrap upward
    loadVal = 10'd1020; loadEn = 1;
    run(1, "R5 load 1020");
    loadEn = 0;
    run(6 * P, "R4 wrap up");
    // R3, R4: count down through zero
    loadVal = 10'd2; loadEn = 1;
    run(1, "R5 load 2");
    loadEn = 0; dirUp = 0;
    run(5 * P, "R4 wrap down");
    // R5: load held across a tick suppresses it
    loadVal = 10'd1009; loadEn = 1;
    run(2 * P, "R5 load held over tick");
    loadEn = 0;
    run(3 * P, "R3 down from 1009");
    // R6: digit patterns with zeros and mixed digits
    loadVal = 10'd987; loadEn = 1;
    run(1, "R6 load 987");
    loadVal = 10'd40;
    run(1, "R6 load 40");
    loadEn = 0; dirUp = 1;
    run(2 * P, "R6 up from 40");
    // R1: reset mid run, then restart of pacing
    rst = 1;
    run(2, "R1 mid-run reset");
    rst = 0;
    run(3 * P, "R2 pacing after reset");
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule